// File: doc/BRIEF.md
# Multi-Context Configuration Store

This block keeps several complete configuration images for a coarse-grained compute array, one per context slot, and presents the image of the selected slot on a wide output vector. A host loads the images in 32-bit words through a single write port that names a slot and a word offset. Any slot may be rewritten in full or in part at any time, including while another slot drives the array.

Switching between stored images takes no reload. The output is a combinational selection from the stored slots, so it follows a change of the active slot number in the same cycle. Each slot carries a valid flag. Reset clears the flags and the stored words. Until a slot has received a write, selecting it yields an all-zero configuration. The image width is a parameter. The default of 918 bits corresponds to a 16-bit datapath, because the image holds a constant operand per cell. The slot count is a parameter with supported values 1, 2, 4 and 8.

Top module: `ctx_cfg_store`

## Requirements
- R1: After reset, every slot is invalid and `cfg_out` is all zero, whichever slot is selected.
- R2: A write with `wr_en` high stores `wr_data` as word `wr_addr` of slot `wr_ctx`. Word k of a slot drives `cfg_out` bits [32k+31:32k].
- R3: The last word (offset 28 at the default width) contributes only its low 22 bits. The upper bits of that write have no effect on `cfg_out`.
- R4: A write with `wr_addr` at or above the word count (29 to 31 at the default width) is ignored. It changes no stored word and does not set the slot's valid flag.
- R5: A partial write changes only the addressed word. All other words of that slot keep their values.
- R6: A write to the slot that is currently active appears on `cfg_out` after the clock edge that takes it, that is, in the next cycle.
- R7: A change of `act_ctx` makes `cfg_out` show the newly selected slot's image in the same cycle, with no reload.
- R8: Any in-range write to a slot sets its valid flag. Selecting a slot whose flag is clear drives all zeros. A slot that has received only some words shows zeros in the words it has not received.
- R9: Writes to slots other than the active one leave `cfg_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host word write strobe |
| wr_ctx | input | 2 | Slot index of the write |
| wr_addr | input | 5 | Word offset of the write |
| wr_data | input | 32 | Configuration word |
| act_ctx | input | 2 | Index of the slot driving the array |
| cfg_out | output | 918 | Configuration bits of the active slot |

## Verification
Two of the block's functions can fall in the same cycle: a host write and the selection of the slot it targets. The bench provokes this both ways. It writes into the active slot and checks the following cycle. It also changes `act_ctx` on the same edge as a write to another slot, so that selection and update overlap. The random phase mixes writes and slot changes with a fixed seed. After every edge it compares `cfg_out` with an image assembled from a word-level model of all slots and their valid flags.

// File: rtl/cfgstore_pkg.sv
package cfgstore_pkg;
  localparam int unsigned CFG_WORD_W = 32;

  function automatic int unsigned words_for(input int unsigned bits);
    return (bits + CFG_WORD_W - 1) / CFG_WORD_W;
  endfunction
endpackage

// File: rtl/cfgstore_rst_sync.sv
module cfgstore_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[1];
endmodule

// File: rtl/cfgstore_slot.sv
module cfgstore_slot #(
  parameter int unsigned NUM_WORDS = 29,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_hit,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [NUM_WORDS*WORD_W-1:0] img,
  output logic                        valid
);
  logic addr_ok;
  logic valid_q;
  logic valid_d;

  assign addr_ok = (32'(wr_addr) < NUM_WORDS);

  always_comb begin
    valid_d = valid_q | (wr_hit & addr_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign valid = valid_q;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic              en_k;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;

    assign en_k = wr_hit && (32'(wr_addr) == k);

    always_comb begin
      word_d = en_k ? wr_data : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (en_k) word_q <= word_d;
    end

    assign img[k*WORD_W +: WORD_W] = word_q;
  end

  // R8: an in-range write leaves the slot valid afterwards
  a_r8_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && addr_ok) |=> valid);

  // R4: an out-of-range offset touches neither data nor flag
  a_r4_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !addr_ok) |=> ($stable(img) && $stable(valid)));
endmodule

// File: rtl/cfgstore_select.sv
module cfgstore_select #(
  parameter int unsigned NUM_CTX = 4,
  parameter int unsigned CTX_W   = 2,
  parameter int unsigned IMG_W   = 928
) (
  input  logic [NUM_CTX-1:0][IMG_W-1:0] imgs,
  input  logic [NUM_CTX-1:0]            valids,
  input  logic [CTX_W-1:0]              act_ctx,
  output logic [IMG_W-1:0]              sel_img
);
  always_comb begin
    sel_img = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if ((32'(act_ctx) == c) && valids[c]) sel_img = imgs[c];
    end
  end
endmodule

// File: rtl/ctx_cfg_store.sv
module ctx_cfg_store #(
  parameter int unsigned NUM_CTX  = 4,
  parameter int unsigned CFG_BITS = 918,
  localparam int unsigned WORD_W    = cfgstore_pkg::CFG_WORD_W,
  localparam int unsigned NUM_WORDS = cfgstore_pkg::words_for(CFG_BITS),
  localparam int unsigned ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CTX_W-1:0]    wr_ctx,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [CTX_W-1:0]    act_ctx,
  output logic [CFG_BITS-1:0] cfg_out
);
  localparam int unsigned IMG_W = NUM_WORDS * WORD_W;

  logic                            rst_q_n;
  logic [NUM_CTX-1:0][IMG_W-1:0]   imgs;
  logic [NUM_CTX-1:0]              valids;
  logic [IMG_W-1:0]                sel_img;

  cfgstore_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_slot
    logic hit;
    assign hit = wr_en && (32'(wr_ctx) == c);

    cfgstore_slot #(
      .NUM_WORDS (NUM_WORDS),
      .ADDR_W    (ADDR_W),
      .WORD_W    (WORD_W)
    ) i_slot (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .wr_hit  (hit),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .img     (imgs[c]),
      .valid   (valids[c])
    );
  end

  cfgstore_select #(
    .NUM_CTX (NUM_CTX),
    .CTX_W   (CTX_W),
    .IMG_W   (IMG_W)
  ) i_select (
    .imgs    (imgs),
    .valids  (valids),
    .act_ctx (act_ctx),
    .sel_img (sel_img)
  );

  assign cfg_out = sel_img[CFG_BITS-1:0];

  // R6: a full word written into the active slot shows in the next cycle
  a_r6_active_write_next: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && (32'(wr_addr) < NUM_WORDS - 1) && (wr_ctx == act_ctx))
    |=> (act_ctx != $past(act_ctx)) ||
        (cfg_out[32'($past(wr_addr)) * WORD_W +: WORD_W] == $past(wr_data)));

  // R9: with no write to the active slot and no selection change, output holds
  a_r9_other_slot_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!wr_en || (wr_ctx != act_ctx)) |=> ((act_ctx != $past(act_ctx)) || $stable(cfg_out)));
endmodule

// File: tb/test_ctx_cfg_store.sv
module test_ctx_cfg_store;
  localparam int unsigned NUM_CTX  = 4;
  localparam int unsigned CFG_BITS = 918;
  localparam int unsigned NW       = (CFG_BITS + 31) / 32;
  localparam int unsigned CLK_PERIOD = 10;

  logic                clk;
  logic                rst_n;
  logic                wr_en;
  logic [1:0]          wr_ctx;
  logic [4:0]          wr_addr;
  logic [31:0]         wr_data;
  logic [1:0]          act_ctx;
  logic [CFG_BITS-1:0] cfg_out;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  bit [31:0] m_word [NUM_CTX][NW];
  bit        m_valid[NUM_CTX];

  ctx_cfg_store #(.NUM_CTX(NUM_CTX), .CFG_BITS(CFG_BITS)) i_ctx_cfg_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctx(wr_ctx),
    .wr_addr(wr_addr), .wr_data(wr_data), .act_ctx(act_ctx), .cfg_out(cfg_out)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [CFG_BITS-1:0] exp_img(input int c);
    logic [NW*32-1:0] t;
    t = '0;
    if (m_valid[c]) for (int k = 0; k < NW; k++) t[k*32 +: 32] = m_word[c][k];
    return t[CFG_BITS-1:0];
  endfunction

  task automatic chk(input string tag, input logic [CFG_BITS-1:0] got, input logic [CFG_BITS-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_wr(input int c, input int a, input bit [31:0] d);
    if (a < NW) begin
      m_word[c][a] = d;
      m_valid[c] = 1;
    end
  endtask

  // drive at a falling edge; returns at the next falling edge with the write taken
  task automatic do_write(input int c, input int a, input bit [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_ctx = 2'(c); wr_addr = 5'(a); wr_data = d;
    model_wr(c, a, d);
    @(negedge clk);
    wr_en = 0;
    #1;
  endtask

  task automatic sel(input int c);
    act_ctx = 2'(c);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        nchk++; nerr++;
        $display("FAIL watchdog: run hung, cycles=%0d expected<=%0d", cyc, 50000);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NUM_CTX; c++) begin
      m_valid[c] = 0;
      for (int k = 0; k < NW; k++) m_word[c][k] = 0;
    end
    rst_n = 0; wr_en = 0; wr_ctx = 0; wr_addr = 0; wr_data = 0; act_ctx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;

    // R1: reset state for every slot
    for (int c = 0; c < NUM_CTX; c++) begin
      sel(c);
      chk("R1 reset zero", cfg_out, '0);
    end

    // R4: out-of-range offset to a fresh slot keeps it invalid
    sel(2);
    do_write(2, 30, 32'hDEAD_BEEF);
    chk("R4 oob no valid", cfg_out, '0);

    // R8: single word into fresh slot sets valid, other words zero
    sel(3);
    do_write(3, 3, 32'h1234_5678);
    chk("R8 partial fresh slot", cfg_out, exp_img(3));
    nchk++;
    if (cfg_out[127:96] !== 32'h1234_5678) begin
      nerr++;
      $display("FAIL R2 word3 position got=%h exp=%h", cfg_out[127:96], 32'h1234_5678);
    end

    // R2: full loads of every slot
    for (int c = 0; c < NUM_CTX; c++)
      for (int k = 0; k < NW; k++) do_write(c, k, $urandom());
    // R7: instant selection
    for (int c = NUM_CTX - 1; c >= 0; c--) begin
      sel(c);
      chk("R7 select same cycle", cfg_out, exp_img(c));
    end

    // R3: last word keeps only its low bits
    sel(1);
    do_write(1, NW - 1, 32'hFFFF_FFFF);
    chk("R3 last word pad", cfg_out, exp_img(1));
    nchk++;
    if (cfg_out[CFG_BITS-1:(NW-1)*32] !== '1) begin
      nerr++;
      $display("FAIL R3 top bits got=%h exp=all ones", cfg_out[CFG_BITS-1:(NW-1)*32]);
    end

    // R4: out-of-range offset to the active slot changes nothing
    do_write(1, 31, 32'h0BAD_F00D);
    chk("R4 oob active", cfg_out, exp_img(1));

    // R5: partial update of one word
    sel(0);
    do_write(0, 7, 32'hA5A5_5A5A);
    chk("R5 partial only word", cfg_out, exp_img(0));

    // R6: write to active slot visible one cycle later
    sel(2);
    @(negedge clk);
    wr_en = 1; wr_ctx = 2; wr_addr = 5; wr_data = 32'hCAFE_0001;
    #1;
    chk("R6 not before edge", cfg_out, exp_img(2));
    model_wr(2, 5, 32'hCAFE_0001);
    @(negedge clk);
    wr_en = 0;
    #1;
    chk("R6 next cycle", cfg_out, exp_img(2));

    // R9: write to another slot while slot 2 is active
    do_write(3, 10, 32'h7777_1111);
    chk("R9 other slot quiet", cfg_out, exp_img(2));

    // R7 with R9: select slot 3 on the same edge as a write to slot 0
    @(negedge clk);
    wr_en = 1; wr_ctx = 0; wr_addr = 2; wr_data = 32'h3C3C_C3C3;
    act_ctx = 3;
    #1;
    chk("R7 switch during write", cfg_out, exp_img(3));
    model_wr(0, 2, 32'h3C3C_C3C3);
    @(negedge clk);
    wr_en = 0;
    #1;
    chk("R9 after switch", cfg_out, exp_img(3));

    // random mix (R2 R5 R6 R7 R9)
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #1;
      chk("R2 random", cfg_out, exp_img(int'(act_ctx)));
      wr_en = 1'($urandom());
      wr_ctx = 2'($urandom());
      wr_addr = 5'($urandom());
      wr_data = $urandom();
      act_ctx = 2'($urandom());
      if (wr_en) model_wr(int'(wr_ctx), int'(wr_addr), wr_data);
    end
    @(negedge clk);
    wr_en = 0;
    #1;
    chk("R2 random last", cfg_out, exp_img(int'(act_ctx)));

    finish_run();
  end
endmodule